// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a single-data-rate SDRAM and takes the memory from power-on to a usable state. When reset is released it holds clock enable and the data mask high and drives a no-operation command. It keeps doing so for a settle interval given in microseconds, which is turned into clock cycles from the clock period parameter. It then issues one precharge that covers all banks, a configurable number of auto-refresh commands and a mode register write. A parameter selects whether the mode register write comes before or after the refreshes. The gaps between commands are filled with no-operation cycles.

The mode register word is built from four configuration inputs: burst length, burst ordering, read latency and single-write mode. Every reserved address bit and both bank bits are forced low. Once the wait after the last command has run out, `init_done` goes high and stays high until the next reset. From then on the command pins rest at no-operation, and the normal controller takes over.

Top module: `sdram_boot_seq`

## Requirements
- R1: While reset is asserted, and for SETTLE_CYC cycles after its release, the command pins show no-operation (cs_n=0, ras_n=1, cas_n=1, we_n=1), address and bank are all zero, and `init_done` is 0.
- R2: In cycle SETTLE_CYC after reset release, the block drives a precharge-all command: cs_n=0, ras_n=0, cas_n=1, we_n=0, address bit 10 high, all other address bits low, bank zero.
- R3: Exactly REF_COUNT auto-refresh commands are issued (cs_n=0, ras_n=0, cas_n=0, we_n=1, address and bank zero). Consecutive refreshes are TRC_CYC cycles apart.
- R4: The first command after the precharge comes TRP_CYC cycles after it. With MRS_FIRST=0 the refreshes come first and the mode write last. With MRS_FIRST=1 the mode write comes first and the refreshes follow it.
- R5: The mode-word layout is: bits 2:0 carry `cfg_burst_len`, bit 3 carries `cfg_burst_interleave`, bits 6:4 carry `cfg_cas_latency` and bit 9 carries `cfg_write_single`. Bits 7, 8, 10, 11 and both bank bits are 0.
- R6: The mode write is encoded with cs_n, ras_n, cas_n and we_n all 0. It is followed by exactly one no-operation cycle, so the next command or `init_done` comes 2 cycles after it.
- R7: Every cycle between commands is a no-operation with address and bank zero. `sd_cke` and `sd_dqm` are 1 in every cycle, including during reset.
- R8: `init_done` rises in the cycle when the final gap expires: 2 cycles after a final mode write, or TRC_CYC cycles after a final refresh. It then stays 1, with the command pins at no-operation, until reset.
- R9: SETTLE_CYC equals the ceiling of SETTLE_US × 1,000,000 / CLK_PERIOD_PS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs change on its rising edge |
| rst_n | input | 1 | Active-low reset; restarts the whole sequence |
| cfg_burst_len | input | 3 | Burst-length code placed in mode-word bits 2:0 |
| cfg_burst_interleave | input | 1 | Burst ordering placed in mode-word bit 3 |
| cfg_cas_latency | input | 3 | Read-latency code placed in mode-word bits 6:4 |
| cfg_write_single | input | 1 | Single-write mode placed in mode-word bit 9 |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address pins; carry the mode word or the all-bank flag |
| sd_bank | output | BANK_W | Bank-select pins |
| sd_cke | output | 1 | Clock enable, held high |
| sd_dqm | output | 1 | Data mask, held high |
| init_done | output | 1 | Sequence complete; sticky until reset |

## Verification
Each fault in the sequencing state appears at the pins as a displaced command, so the bench compares every pin against an arithmetic schedule on every cycle:
- A wrong settle count moves the precharge by that many cycles.
- A wrong gap count moves each later command by the same amount.
- A wrong refresh counter adds or drops a refresh, and this shows no later than the cycle where the mode write or `init_done` was due.

Mode-word mistakes appear only in the single mode-write cycle. For that reason the configuration inputs are swept over several runs, and both orderings run side by side.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

   typedef enum logic [2:0] {
      ST_SETTLE,
      ST_PRE,
      ST_REF,
      ST_MRS,
      ST_GAP,
      ST_DONE
   } seq_state_t;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } cmd_pins_t;

   localparam cmd_pins_t PINS_NOP = cmd_pins_t'(4'b0111);
   localparam cmd_pins_t PINS_PRE = cmd_pins_t'(4'b0010);
   localparam cmd_pins_t PINS_REF = cmd_pins_t'(4'b0001);
   localparam cmd_pins_t PINS_MRS = cmd_pins_t'(4'b0000);

   // Fixed completion time of a mode-register write, in cycles.
   localparam int MODE_WR_CYC = 2;

   function automatic cmd_pins_t pins_for(seq_state_t s);
      case (s)
         ST_PRE:  return PINS_PRE;
         ST_REF:  return PINS_REF;
         ST_MRS:  return PINS_MRS;
         default: return PINS_NOP;
      endcase
   endfunction

   function automatic int max3(int a, int b, int c);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      return m;
   endfunction

   function automatic int bits_for(int v);
      return (v < 2) ? 1 : $clog2(v + 1);
   endfunction

endpackage

// File: rtl/sdinit_timer.sv
module sdinit_timer #(
   parameter int CNT_W   = 8,
   parameter int RST_VAL = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   if (RST_VAL < 0 || RST_VAL >= (2 ** CNT_W)) begin : g_bad_rst
      $error("sdinit_timer: reset value does not fit the counter width");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CNT_W'(RST_VAL);
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign expired = (cnt_q == '0);

   // R7: an unloaded, running count steps down by exactly one
   a_r7_timer_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/sdinit_modeword.sv
module sdinit_modeword #(
   parameter int ADDR_W = 12,
   parameter int BANK_W = 2
) (
   input  logic [2:0]        burst_len,
   input  logic              burst_interleave,
   input  logic [2:0]        cas_latency,
   input  logic              write_single,
   output logic [ADDR_W-1:0] word,
   output logic [BANK_W-1:0] bank_word
);

   localparam int BL_LSB = 0;
   localparam int BT_BIT = 3;
   localparam int CL_LSB = 4;
   localparam int WB_BIT = 9;

   if (ADDR_W < 11) begin : g_bad_addr
      $error("sdinit_modeword: address must reach bit 10");
   end

   for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
      if (i >= BL_LSB && i < BL_LSB + 3) begin : g_bl
         assign word[i] = burst_len[i - BL_LSB];
      end else if (i == BT_BIT) begin : g_bt
         assign word[i] = burst_interleave;
      end else if (i >= CL_LSB && i < CL_LSB + 3) begin : g_cl
         assign word[i] = cas_latency[i - CL_LSB];
      end else if (i == WB_BIT) begin : g_wb
         assign word[i] = write_single;
      end else begin : g_rsv
         assign word[i] = 1'b0;
      end
   end

   assign bank_word = '0;

endmodule

// File: rtl/sdinit_ctrl.sv
module sdinit_ctrl
   import sdinit_pkg::*;
#(
   parameter int CLK_PERIOD_PS = 10000,
   parameter int SETTLE_US     = 200,
   parameter int TRP_CYC       = 3,
   parameter int TRC_CYC       = 8,
   parameter int REF_COUNT     = 2,
   parameter bit MRS_FIRST     = 1'b0,
   parameter int ADDR_W        = 12,
   parameter int BANK_W        = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] mode_word,
   input  logic [BANK_W-1:0] mode_bank,
   output cmd_pins_t         cmd_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [BANK_W-1:0] bank_o,
   output logic              done_o
);

   localparam longint SETTLE_PS  = longint'(SETTLE_US) * 64'd1000000;
   localparam int     SETTLE_CYC = int'((SETTLE_PS + longint'(CLK_PERIOD_PS) - 1)
                                        / longint'(CLK_PERIOD_PS));
   localparam int     CNT_MAX    = max3(SETTLE_CYC - 1, TRP_CYC - 2, TRC_CYC - 2);
   localparam int     CNT_W      = bits_for(CNT_MAX);
   localparam int     REF_W      = bits_for(REF_COUNT);
   localparam int     AP_BIT     = 10;
   localparam logic [ADDR_W-1:0] AP_MASK = ADDR_W'(1) << AP_BIT;

   if (CLK_PERIOD_PS < 1)     begin : g_bad_clk  $error("clock period must be positive");      end
   if (SETTLE_CYC < 1)        begin : g_bad_set  $error("settle time must be at least a cycle"); end
   if (TRP_CYC < 2)           begin : g_bad_trp  $error("precharge gap must be >= 2");         end
   if (TRC_CYC < 2)           begin : g_bad_trc  $error("refresh gap must be >= 2");           end
   if (REF_COUNT < 2)         begin : g_bad_ref  $error("at least two refreshes required");    end
   if (ADDR_W < AP_BIT + 1)   begin : g_bad_aw   $error("address too narrow for all-bank bit"); end

   seq_state_t       state_q, state_d;
   logic [REF_W-1:0] refs_left_q;
   logic             mrs_done_q;
   logic             gap_load;
   logic [CNT_W-1:0] gap_val;
   logic             gap_expired;
   logic             pick_mrs;

   // Gap length loaded when leaving an issue state (length minus two:
   // one cycle is the command itself, one is the expiry cycle).
   always_comb begin
      gap_load = (state_q == ST_PRE) || (state_q == ST_REF) || (state_q == ST_MRS);
      case (state_q)
         ST_PRE:  gap_val = CNT_W'(TRP_CYC - 2);
         ST_REF:  gap_val = CNT_W'(TRC_CYC - 2);
         default: gap_val = CNT_W'(MODE_WR_CYC - 2);
      endcase
   end

   sdinit_timer #(
      .CNT_W   (CNT_W),
      .RST_VAL (SETTLE_CYC - 1)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (gap_load),
      .load_val (gap_val),
      .expired  (gap_expired)
   );

   if (MRS_FIRST) begin : g_mode_first
      assign pick_mrs = !mrs_done_q;
   end else begin : g_mode_last
      assign pick_mrs = !mrs_done_q && (refs_left_q == '0);
   end

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_SETTLE: if (gap_expired) state_d = ST_PRE;
         ST_PRE,
         ST_REF,
         ST_MRS:    state_d = ST_GAP;
         ST_GAP: begin
            if (gap_expired) begin
               if (pick_mrs)                 state_d = ST_MRS;
               else if (refs_left_q != '0)   state_d = ST_REF;
               else                          state_d = ST_DONE;
            end
         end
         ST_DONE:   state_d = ST_DONE;
         default:   state_d = ST_SETTLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_SETTLE;
         refs_left_q <= REF_W'(REF_COUNT);
         mrs_done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_REF) refs_left_q <= refs_left_q - REF_W'(1);
         if (state_q == ST_MRS) mrs_done_q  <= 1'b1;
      end
   end

   // Output registers follow the next state, so pins change on the same
   // edge as the state.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_o  <= PINS_NOP;
         addr_o <= '0;
         bank_o <= '0;
         done_o <= 1'b0;
      end else begin
         cmd_o  <= pins_for(state_d);
         done_o <= (state_d == ST_DONE);
         case (state_d)
            ST_PRE: begin
               addr_o <= AP_MASK;
               bank_o <= '0;
            end
            ST_MRS: begin
               addr_o <= mode_word;
               bank_o <= mode_bank;
            end
            default: begin
               addr_o <= '0;
               bank_o <= '0;
            end
         endcase
      end
   end

   // Checker state: refreshes seen on the command outputs
   logic [REF_W:0] refs_seen_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  refs_seen_q <= '0;
      else if (cmd_o == PINS_REF)  refs_seen_q <= refs_seen_q + (REF_W+1)'(1);
   end

   // R8: completion is sticky until reset
   a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> done_o);

   // R8: nothing but no-operation once complete
   a_r8_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (cmd_o == PINS_NOP));

   // R6: a mode write is followed by a no-operation cycle
   a_r6_mode_write_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == PINS_MRS) |=> (cmd_o == PINS_NOP));

   // R2: precharge carries the all-bank flag and nothing else
   a_r2_precharge_all: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == PINS_PRE) |-> (addr_o == AP_MASK && bank_o == '0));

   // R3: exactly the configured number of refreshes before completion
   a_r3_refresh_total: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> (refs_seen_q == (REF_W+1)'(REF_COUNT)));

endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
   import sdinit_pkg::*;
#(
   parameter int CLK_PERIOD_PS = 10000,
   parameter int SETTLE_US     = 200,
   parameter int TRP_CYC       = 3,
   parameter int TRC_CYC       = 8,
   parameter int REF_COUNT     = 2,
   parameter bit MRS_FIRST     = 1'b0,
   parameter int ADDR_W        = 12,
   parameter int BANK_W        = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cfg_burst_len,
   input  logic              cfg_burst_interleave,
   input  logic [2:0]        cfg_cas_latency,
   input  logic              cfg_write_single,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic [ADDR_W-1:0] sd_addr,
   output logic [BANK_W-1:0] sd_bank,
   output logic              sd_cke,
   output logic              sd_dqm,
   output logic              init_done
);

   localparam logic [ADDR_W-1:0] RSV_MASK = ~(ADDR_W'(12'h27F));

   logic [ADDR_W-1:0] mode_word;
   logic [BANK_W-1:0] mode_bank;
   cmd_pins_t         cmd;

   sdinit_modeword #(
      .ADDR_W (ADDR_W),
      .BANK_W (BANK_W)
   ) u_word (
      .burst_len        (cfg_burst_len),
      .burst_interleave (cfg_burst_interleave),
      .cas_latency      (cfg_cas_latency),
      .write_single     (cfg_write_single),
      .word             (mode_word),
      .bank_word        (mode_bank)
   );

   sdinit_ctrl #(
      .CLK_PERIOD_PS (CLK_PERIOD_PS),
      .SETTLE_US     (SETTLE_US),
      .TRP_CYC       (TRP_CYC),
      .TRC_CYC       (TRC_CYC),
      .REF_COUNT     (REF_COUNT),
      .MRS_FIRST     (MRS_FIRST),
      .ADDR_W        (ADDR_W),
      .BANK_W        (BANK_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_word (mode_word),
      .mode_bank (mode_bank),
      .cmd_o     (cmd),
      .addr_o    (sd_addr),
      .bank_o    (sd_bank),
      .done_o    (init_done)
   );

   assign sd_cs_n  = cmd.cs_n;
   assign sd_ras_n = cmd.ras_n;
   assign sd_cas_n = cmd.cas_n;
   assign sd_we_n  = cmd.we_n;
   assign sd_cke   = 1'b1;
   assign sd_dqm   = 1'b1;

   // R5: reserved mode bits and bank bits are low during a mode write
   a_r5_reserved_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!sd_cs_n && !sd_ras_n && !sd_cas_n && !sd_we_n)
         |-> ((sd_addr & RSV_MASK) == '0 && sd_bank == '0));

   // R5: mode fields match the configuration inputs sampled at issue
   a_r5_fields_match: assert property (@(posedge clk) disable iff (!rst_n)
      (!sd_cs_n && !sd_ras_n && !sd_cas_n && !sd_we_n)
         |-> (sd_addr[2:0] == $past(cfg_burst_len) && sd_addr[6:4] == $past(cfg_cas_latency)));

endmodule

// File: tb/sim_sdram_boot_seq.sv
module sim_sdram_boot_seq;

   localparam int CLK_PS  = 7000;
   localparam int SET_US  = 1;
   localparam int TRP     = 3;
   localparam int TRC     = 4;
   localparam int NREF    = 3;
   localparam int MRD     = 2;
   localparam int S       = (SET_US * 1000000 + CLK_PS - 1) / CLK_PS;
   localparam int LAST    = S + TRP + NREF * TRC + MRD + 4;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst_n;
   logic [2:0] bl, cl;
   logic       bt, wb;

   logic        cs0, ras0, cas0, we0, cke0, dqm0, done0;
   logic [11:0] addr0;
   logic [1:0]  bank0;
   logic        cs1, ras1, cas1, we1, cke1, dqm1, done1;
   logic [11:0] addr1;
   logic [1:0]  bank1;

   sdram_boot_seq #(
      .CLK_PERIOD_PS (CLK_PS), .SETTLE_US (SET_US), .TRP_CYC (TRP),
      .TRC_CYC (TRC), .REF_COUNT (NREF), .MRS_FIRST (1'b0)
   ) u0 (
      .clk (clk), .rst_n (rst_n), .cfg_burst_len (bl), .cfg_burst_interleave (bt),
      .cfg_cas_latency (cl), .cfg_write_single (wb),
      .sd_cs_n (cs0), .sd_ras_n (ras0), .sd_cas_n (cas0), .sd_we_n (we0),
      .sd_addr (addr0), .sd_bank (bank0), .sd_cke (cke0), .sd_dqm (dqm0),
      .init_done (done0)
   );

   sdram_boot_seq #(
      .CLK_PERIOD_PS (CLK_PS), .SETTLE_US (SET_US), .TRP_CYC (TRP),
      .TRC_CYC (TRC), .REF_COUNT (NREF), .MRS_FIRST (1'b1)
   ) u1 (
      .clk (clk), .rst_n (rst_n), .cfg_burst_len (bl), .cfg_burst_interleave (bt),
      .cfg_cas_latency (cl), .cfg_write_single (wb),
      .sd_cs_n (cs1), .sd_ras_n (ras1), .sd_cas_n (cas1), .sd_we_n (we1),
      .sd_addr (addr1), .sd_bank (bank1), .sd_cke (cke1), .sd_dqm (dqm1),
      .init_done (done1)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   task automatic check(input string req, input logic [20:0] act, input logic [20:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%06h expected=%06h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_int(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // 0 settle, 1 precharge, 2 refresh, 3 mode write, 4 gap, 5 done
   function automatic int kind_at(int c, bit mf);
      int t;
      if (c < S)  return 0;
      if (c == S) return 1;
      t = S + TRP;
      if (mf) begin
         if (c == t) return 3;
         t += MRD;
         for (int k = 0; k < NREF; k++) begin
            if (c == t) return 2;
            t += TRC;
         end
      end else begin
         for (int k = 0; k < NREF; k++) begin
            if (c == t) return 2;
            t += TRC;
         end
         if (c == t) return 3;
         t += MRD;
      end
      if (c >= t) return 5;
      return 4;
   endfunction

   function automatic logic [20:0] expect_vec(int kind);
      logic [3:0]  pins;
      logic [11:0] a;
      pins = 4'b0111;
      a    = 12'h000;
      case (kind)
         1: begin pins = 4'b0010; a = 12'h400; end
         2: pins = 4'b0001;
         3: begin pins = 4'b0000; a = {2'b00, wb, 2'b00, cl, bt, bl}; end
         default: ;
      endcase
      return {pins, 1'b1, 1'b1, (kind == 5), 2'b00, a};
   endfunction

   function automatic string tag_of(int kind);
      case (kind)
         0: return "R1 settle";
         1: return "R2 precharge";
         2: return "R3 refresh";
         3: return "R5 R6 mode write";
         4: return "R7 gap";
         default: return "R8 done";
      endcase
   endfunction

   task automatic summary();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL R8 watchdog: actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      bl = 3'd0; cl = 3'd0; bt = 1'b0; wb = 1'b0;
      for (int run = 0; run < 8; run++) begin
         int first0, mrs0, mrs1;
         logic [2:0] rv;
         rv = 3'(run);
         bl = rv;
         bt = rv[0];
         cl = 3'(run + 3);
         wb = rv[1] ^ rv[2];
         first0 = -1; mrs0 = -1; mrs1 = -1;
         rst_n = 1'b0;
         repeat (3) @(negedge clk);
         // R1 R7: reset state of both instances
         check("R1 R7 reset u0", {cs0, ras0, cas0, we0, cke0, dqm0, done0, bank0, addr0}, expect_vec(0));
         check("R1 R7 reset u1", {cs1, ras1, cas1, we1, cke1, dqm1, done1, bank1, addr1}, expect_vec(0));
         rst_n = 1'b1;
         for (int c = 0; c <= LAST; c++) begin
            int k0, k1;
            k0 = kind_at(c, 1'b0);
            k1 = kind_at(c, 1'b1);
            check({tag_of(k0), " R4 u0"}, {cs0, ras0, cas0, we0, cke0, dqm0, done0, bank0, addr0}, expect_vec(k0));
            check({tag_of(k1), " R4 u1"}, {cs1, ras1, cas1, we1, cke1, dqm1, done1, bank1, addr1}, expect_vec(k1));
            if (first0 < 0 && {cs0, ras0, cas0, we0} != 4'b0111) first0 = c;
            if ({cs0, ras0, cas0, we0} == 4'b0000) mrs0 = c;
            if ({cs1, ras1, cas1, we1} == 4'b0000) mrs1 = c;
            @(negedge clk);
         end
         // R9: settle length from the period arithmetic
         check_int("R9 settle cycles", first0, S);
         // R4: position of the mode write under each ordering
         check_int("R4 mode write last", mrs0, S + TRP + NREF * TRC);
         check_int("R4 mode write first", mrs1, S + TRP);
      end
      finished = 1'b1;
      summary();
      $finish;
   end

endmodule